// File: doc/BRIEF.md
# Disk Bus-Master DMA Channel

This block is one bus-master DMA channel for a disk interface. Software programs it through an 8-byte register window: it loads the physical base address of a descriptor table, picks the transfer direction, clears the sticky status bits and sets the run bit. The engine then walks the table in memory. Each entry is 8 bytes. The first 32-bit word holds the buffer address. The second word holds the byte count in its low `LEN_W` bits and the end-of-table flag in bit 31. For each entry the engine moves 16-bit words between the drive-side handshake and a memory request port. It stops once the byte count of the entry that carries the end-of-table flag reaches zero. It then raises the interrupt bit.

All data streams use valid/ready. On `mem_req_*` and `drv_out_*` the engine holds valid, address and data steady until the partner asserts ready. On `drv_in_*` the drive may hold valid as long as it likes; the engine accepts a word only in a cycle where `drv_in_ready` is high. Memory read responses come back on `mem_rsp_valid`, exactly one per accepted read, at least one cycle after the request. The engine always accepts them, so the response port has no ready. Buffers must be 16-bit aligned, and no region may cross a 64 KB boundary.

Software must not restart the channel while a memory read is still outstanding after an abort.

Top module: `disk_bm_dma`

## Requirements
- R1: After reset, the command, status and pointer registers read 0. `irq` is low, and no memory request, drive-out word or drive-in ready is presented.
- R2: A write to the pointer register (offset 4) stores the value with bits [1:0] forced to 0. A pointer write while the channel is active leaves the stored pointer unchanged.
- R3: Writing the command register (offset 0) with bit 0 = 1 starts the channel, provided the stored bit 0 was 0 and the channel is idle. The engine first reads the 32-bit words at pointer and pointer+4. Word 0 gives the buffer address. In word 1, bits [LEN_W-1:0] give the byte count and bit 31 marks end of table. The next entry follows 8 bytes further on.
- R4: With command bit 3 = 1 (drive to memory), each word accepted on `drv_in` is written to memory at the current buffer address. The address then advances by 2 and the count drops by 2.
- R5: With command bit 3 = 0 (memory to drive), each word is read from memory at the current buffer address. Bits [15:0] of the response are presented on `drv_out`.
- R6: A byte count field of 0 means 2^LEN_W bytes.
- R7: When the end-of-table entry is exhausted, the status register (offset 2) bit 0 (active) clears and bit 2 (interrupt) sets, so status bits [2:0] read 3'b100. `irq` follows bit 2.
- R8: If `drv_dreq` is still high in the cycle after the last word of the table, status bit 1 (error) is set as well as bit 2.
- R9: In the status register, writing 1 to bit 1 or bit 2 clears that bit, and writing 0 leaves it alone. Bits 5 and 6 store the written value. Bit 0 ignores writes. Writing 0x26 leaves 0x20.
- R10: Writing command bit 0 = 0 while active aborts the transfer. Active clears, the interrupt bit is not set, and no further memory request is issued.
- R11: A memory request or drive-out word stalled by a low ready stays valid, with the same address and data, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 command, 2 status, 4 pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, equal to status bit 2 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write word, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| drv_dreq | input | 1 | Drive is requesting data transfer |
| drv_in_valid | input | 1 | Drive word available (drive to memory) |
| drv_in_ready | output | 1 | Engine accepts the drive word |
| drv_in_data | input | 16 | Drive word |
| drv_out_valid | output | 1 | Word for the drive valid (memory to drive) |
| drv_out_ready | input | 1 | Drive accepts the word |
| drv_out_data | output | 16 | Word for the drive |

## Verification
The bench builds the channel with `LEN_W` = 4 and `ADDR_W` = 32. A zero count field therefore means 16 bytes, and the wrap case takes only eight words, next to an ordinary 6-byte entry in the same table. Ready and valid on the memory and drive ports follow a pseudo-random pattern, so stalls land in every fetch and data state. The error-on-late-request case and the abort are each reachable in a few dozen cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int WORD_W = 16;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int CMD_RUN    = 0;
  localparam int CMD_TO_MEM = 3;
  localparam int ST_ERR     = 1;
  localparam int ST_IRQ     = 2;
  localparam int DESC_LAST  = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_DA_REQ, S_DA_WAIT, S_DB_REQ, S_DB_WAIT,
    S_GET, S_RWAIT, S_PUT, S_FINISH
  } seq_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              fault,
  output logic              start,
  output logic              start_dir,
  output logic              abort,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic              irq
);
  logic run_q, dir_q, err_q, irq_q;
  logic [1:0] spare_q;
  logic [ADDR_W-1:0] ptr_q;

  logic cmd_wr, st_wr, ptr_wr;
  assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);
  assign st_wr  = reg_wr && (reg_addr == OFS_STAT);
  assign ptr_wr = reg_wr && (reg_addr == OFS_PTR);

  assign start     = cmd_wr && reg_wdata[CMD_RUN] && !run_q && !busy;
  assign start_dir = reg_wdata[CMD_TO_MEM];
  assign abort     = cmd_wr && !reg_wdata[CMD_RUN] && busy;
  assign tbl_ptr   = ptr_q;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      spare_q <= 2'b00;
      ptr_q   <= '0;
    end else begin
      if (cmd_wr) begin
        run_q <= reg_wdata[CMD_RUN];
        dir_q <= reg_wdata[CMD_TO_MEM];
      end
      if (st_wr) spare_q <= reg_wdata[6:5];
      if (fault) err_q <= 1'b1;
      else if (st_wr && reg_wdata[ST_ERR]) err_q <= 1'b0;
      if (done) irq_q <= 1'b1;
      else if (st_wr && reg_wdata[ST_IRQ]) irq_q <= 1'b0;
      if (ptr_wr && !busy) ptr_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CMD:  reg_rdata = {28'd0, dir_q, 2'b00, run_q};
      OFS_STAT: reg_rdata = {25'd0, spare_q, 2'b00, irq_q, err_q, busy};
      OFS_PTR:  reg_rdata = 32'(ptr_q);
      default:  reg_rdata = 32'd0;
    endcase
  end

  logic unused_regs;
  assign unused_regs = ^reg_wdata;

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ptr_wr |=> $stable(ptr_q)); // R2
  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_q); // R7
  AST_FAULT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> err_q); // R8
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic              abort,
  input  logic [ADDR_W-1:0] tbl_ptr,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              drv_dreq,
  input  logic              drv_in_valid,
  output logic              drv_in_ready,
  input  logic [WORD_W-1:0] drv_in_data,
  output logic              drv_out_valid,
  input  logic              drv_out_ready,
  output logic [WORD_W-1:0] drv_out_data
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = {1'b1, {LEN_W{1'b0}}};
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(WORD_W / 8);

  seq_state_t state;
  logic dir_q, eot_q;
  logic [ADDR_W-1:0] dptr, baddr;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word;
  logic put_fire;

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FINISH);
  assign fault = done && drv_dreq;

  assign mem_req_valid = (state == S_DA_REQ) || (state == S_DB_REQ) ||
                         ((state == S_GET) && !dir_q) || ((state == S_PUT) && dir_q);
  assign mem_req_we    = (state == S_PUT);
  assign mem_req_wdata = word;
  assign drv_in_ready  = (state == S_GET) && dir_q;
  assign drv_out_valid = (state == S_PUT) && !dir_q;
  assign drv_out_data  = word;
  assign put_fire      = dir_q ? mem_req_ready : drv_out_ready;

  always_comb begin
    case (state)
      S_DA_REQ: mem_req_addr = dptr;
      S_DB_REQ: mem_req_addr = dptr + ADDR_W'(4);
      default:  mem_req_addr = baddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dir_q <= 1'b0;
      eot_q <= 1'b0;
      dptr  <= '0;
      baddr <= '0;
      cnt   <= '0;
      word  <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_DA_REQ;
          dir_q <= start_dir;
          dptr  <= tbl_ptr;
        end
        S_DA_REQ: if (mem_req_ready) state <= S_DA_WAIT;
        S_DA_WAIT: if (mem_rsp_valid) begin
          baddr <= {mem_rsp_data[ADDR_W-1:1], 1'b0};
          state <= S_DB_REQ;
        end
        S_DB_REQ: if (mem_req_ready) state <= S_DB_WAIT;
        S_DB_WAIT: if (mem_rsp_valid) begin
          cnt   <= (mem_rsp_data[LEN_W-1:0] == '0) ? FULL_CNT
                                                   : {1'b0, mem_rsp_data[LEN_W-1:0]};
          eot_q <= mem_rsp_data[DESC_LAST];
          dptr  <= dptr + ADDR_W'(8);
          state <= S_GET;
        end
        S_GET: begin
          if (dir_q) begin
            if (drv_in_valid) begin
              word  <= drv_in_data;
              state <= S_PUT;
            end
          end else if (mem_req_ready) begin
            state <= S_RWAIT;
          end
        end
        S_RWAIT: if (mem_rsp_valid) begin
          word  <= mem_rsp_data[WORD_W-1:0];
          state <= S_PUT;
        end
        S_PUT: if (put_fire) begin
          baddr <= baddr + ADDR_W'(WORD_W / 8);
          cnt   <= cnt - STEP;
          if (cnt <= STEP) state <= eot_q ? S_FINISH : S_DA_REQ;
          else             state <= S_GET;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  logic unused_seq;
  assign unused_seq = ^mem_rsp_data;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !drv_in_ready && !drv_out_valid); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !abort |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)); // R11
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drv_out_valid && !drv_out_ready && !abort |=> drv_out_valid && $stable(drv_out_data)); // R11
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !mem_req_valid); // R10
endmodule

// File: rtl/disk_bm_dma.sv
module disk_bm_dma
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [15:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              drv_dreq,
  input  logic              drv_in_valid,
  output logic              drv_in_ready,
  input  logic [15:0]       drv_in_data,
  output logic              drv_out_valid,
  input  logic              drv_out_ready,
  output logic [15:0]       drv_out_data
);
  logic busy, done, fault, start, start_dir, abort;
  logic [ADDR_W-1:0] tbl_ptr;

  dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .fault(fault),
    .start(start), .start_dir(start_dir), .abort(abort),
    .tbl_ptr(tbl_ptr), .irq(irq)
  );

  dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_dir(start_dir), .abort(abort), .tbl_ptr(tbl_ptr),
    .busy(busy), .done(done), .fault(fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .drv_dreq(drv_dreq),
    .drv_in_valid(drv_in_valid), .drv_in_ready(drv_in_ready), .drv_in_data(drv_in_data),
    .drv_out_valid(drv_out_valid), .drv_out_ready(drv_out_ready), .drv_out_data(drv_out_data)
  );
endmodule

// File: tb/sim_disk_bm_dma.sv
module sim_disk_bm_dma;
  localparam int AW = 32;
  localparam int LW = 4;
  localparam logic [15:0] STEPV = 16'h1357;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, reg_wr, irq;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [15:0] mem_req_wdata, drv_in_data, drv_out_data;
  logic [31:0] mem_rsp_data;
  logic drv_dreq, drv_in_valid, drv_in_ready, drv_out_valid, drv_out_ready;

  disk_bm_dma #(.ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .drv_dreq(drv_dreq),
    .drv_in_valid(drv_in_valid), .drv_in_ready(drv_in_ready), .drv_in_data(drv_in_data),
    .drv_out_valid(drv_out_valid), .drv_out_ready(drv_out_ready), .drv_out_data(drv_out_data)
  );

  typedef struct packed { logic we; logic [31:0] addr; logic [15:0] data; } op_t;
  op_t   exp_mem[$];
  string exp_tag[$];
  logic [15:0] exp_drv[$];
  logic [31:0] dmem [logic [31:0]];

  int checks = 0, errors = 0, cyc = 0, req_seen = 0;
  logic [15:0] src_word = 16'h0;
  bit keep_dreq = 0, stall_drv = 0, rsp_pend = 0, prev_hold = 0;
  logic [31:0] rsp_next = '0, prev_addr = '0;
  logic [7:0] lfsr = 8'hA7;

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[16:1] ^ 16'hA55A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_op(input logic we, input logic [31:0] a, input logic [15:0] d,
                           input string tag);
    exp_mem.push_back('{we: we, addr: a, data: d});
    exp_tag.push_back(tag);
  endtask

  // Reference model of the memory and drive sides, evaluated every clock
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    drv_dreq = 0; drv_in_valid = 0; drv_in_data = '0; drv_out_ready = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = rsp_pend;
      mem_rsp_data  = rsp_next;
      rsp_pend      = 0;
      lfsr          = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[3];
      drv_in_valid  = !stall_drv && (lfsr[1] | lfsr[2]);
      drv_in_data   = src_word;
      drv_out_ready = lfsr[2] | lfsr[4];
      drv_dreq      = keep_dreq || (exp_mem.size() != 0) || (exp_drv.size() != 0);
      #1;
      if (prev_hold)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R11", "stalled request moved",
            mem_req_addr, prev_addr);
      prev_hold = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid) req_seen++;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_mem.size() == 0) begin
          chk(0, "R3", "unexpected memory request", mem_req_addr, 32'hFFFF_FFFF);
        end else begin
          op_t e; string t;
          e = exp_mem.pop_front();
          t = exp_tag.pop_front();
          chk(mem_req_we == e.we && mem_req_addr == e.addr, t, "memory request addr",
              mem_req_addr, e.addr);
          if (e.we) chk(mem_req_wdata == e.data, t, "memory write data",
                        32'(mem_req_wdata), 32'(e.data));
        end
        if (!mem_req_we) begin
          rsp_pend = 1;
          rsp_next = dmem.exists(mem_req_addr) ? dmem[mem_req_addr] : {16'h0, pat(mem_req_addr)};
        end
      end
      if (drv_in_valid && drv_in_ready) src_word = src_word + STEPV;
      if (drv_out_valid && drv_out_ready) begin
        if (exp_drv.size() == 0) chk(0, "R5", "unexpected drive word", 32'(drv_out_data), 0);
        else begin
          logic [15:0] w;
          w = exp_drv.pop_front();
          chk(drv_out_data == w, "R5", "drive word", 32'(drv_out_data), 32'(w));
        end
      end
      if (cyc > 150000) begin
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    #1 chk(irq, tag, "irq pin after table end", 32'(irq), 1);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] s;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    rd(3'd0, v); chk(v == 0, "R1", "command after reset", v, 0);
    rd(3'd2, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1", "pointer after reset", v, 0);
    chk(!mem_req_valid && !irq && !drv_out_valid && !drv_in_ready, "R1", "outputs idle after reset",
        {mem_req_valid, irq, drv_out_valid, drv_in_ready}, 0);

    wr(3'd4, 32'h0000_0103);
    rd(3'd4, v); chk(v == 32'h100, "R2", "pointer low bits forced", v, 32'h100);

    // Two-entry table, drive to memory; second entry uses count 0 (16 bytes)
    dmem[32'h100] = 32'h0000_2000; dmem[32'h104] = 32'h0000_0006;
    dmem[32'h108] = 32'h0000_3000; dmem[32'h10C] = 32'h8000_0000;
    s = 16'h1000; src_word = s;
    expect_op(0, 32'h100, 0, "R3"); expect_op(0, 32'h104, 0, "R3");
    for (int k = 0; k < 3; k++) expect_op(1, 32'h2000 + 2*k, s + STEPV*16'(k), "R4");
    expect_op(0, 32'h108, 0, "R3"); expect_op(0, 32'h10C, 0, "R3");
    for (int k = 0; k < 8; k++) expect_op(1, 32'h3000 + 2*k, s + STEPV*16'(k+3), "R6");
    wr(3'd2, 32'h06);
    wr(3'd0, 32'h09);
    rd(3'd2, v); chk(v[0] == 1'b1, "R7", "active while running", v, 1);
    wr(3'd4, 32'h0000_0500);
    rd(3'd4, v); chk(v == 32'h100, "R2", "pointer write ignored while active", v, 32'h100);
    wait_irq("R7");
    chk(exp_mem.size() == 0, "R6", "words left of zero-count entry", exp_mem.size(), 0);
    rd(3'd2, v); chk(v[2:0] == 3'b100, "R7", "status after good transfer", v, 32'h4);

    wr(3'd2, 32'h26);
    rd(3'd2, v); chk(v == 32'h20, "R9", "status after writing 0x26", v, 32'h20);
    chk(!irq, "R9", "irq pin after clear", 32'(irq), 0);
    wr(3'd2, 32'h00);
    rd(3'd2, v); chk(v == 32'h00, "R9", "bit 5 written back to 0", v, 0);

    // Memory to drive
    wr(3'd0, 32'h00);
    dmem[32'h200] = 32'h0000_4000; dmem[32'h204] = 32'h8000_0004;
    expect_op(0, 32'h200, 0, "R3"); expect_op(0, 32'h204, 0, "R3");
    expect_op(0, 32'h4000, 0, "R5"); expect_op(0, 32'h4002, 0, "R5");
    exp_drv.push_back(pat(32'h4000)); exp_drv.push_back(pat(32'h4002));
    wr(3'd4, 32'h200);
    wr(3'd0, 32'h01);
    wait_irq("R7");
    chk(exp_drv.size() == 0, "R5", "drive words outstanding", exp_drv.size(), 0);
    rd(3'd2, v); chk(v == 32'h04, "R7", "status after memory-to-drive", v, 32'h4);
    wr(3'd2, 32'h00);
    rd(3'd2, v); chk(v == 32'h04, "R9", "writing 0 keeps interrupt bit", v, 32'h4);
    wr(3'd2, 32'h04);

    // Drive still requesting at the end
    wr(3'd0, 32'h00);
    dmem[32'h300] = 32'h0000_5000; dmem[32'h304] = 32'h8000_0002;
    s = 16'h2222; src_word = s; keep_dreq = 1;
    expect_op(0, 32'h300, 0, "R3"); expect_op(0, 32'h304, 0, "R3");
    expect_op(1, 32'h5000, s, "R4");
    wr(3'd4, 32'h300);
    wr(3'd0, 32'h09);
    wait_irq("R8");
    rd(3'd2, v); chk(v == 32'h06, "R8", "status with late drive request", v, 32'h6);
    keep_dreq = 0;
    wr(3'd2, 32'h06);

    // Abort while waiting on the drive
    wr(3'd0, 32'h08);
    stall_drv = 1;
    dmem[32'h400] = 32'h0000_6000; dmem[32'h404] = 32'h8000_0000;
    expect_op(0, 32'h400, 0, "R3"); expect_op(0, 32'h404, 0, "R3");
    wr(3'd4, 32'h400);
    wr(3'd0, 32'h09);
    repeat (30) @(negedge clk);
    rd(3'd2, v); chk(v == 32'h01, "R10", "active before abort", v, 32'h1);
    wr(3'd0, 32'h08);
    req_seen = 0;
    repeat (12) @(negedge clk);
    chk(req_seen == 0, "R10", "memory requests after abort", req_seen, 0);
    rd(3'd2, v); chk(v == 32'h00, "R10", "status after abort", v, 0);
    chk(exp_mem.size() == 0, "R3", "descriptor reads before abort", exp_mem.size(), 0);
    stall_drv = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule